// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Unit

This unit serves one processor's view of a small interrupt controller. It handles two operations. The first is the acknowledge read, which claims the most urgent pending interrupt. The second is the end-of-interrupt write, which retires an interrupt the processor has finished with. The unit tracks which interrupt is running and at what priority. It also tracks how active interrupts are nested, using a table that gives each interrupt a back link to the interrupt it preempted. Selecting the most urgent pending interrupt is done elsewhere. This unit only receives the winner's ID and priority, together with the per-interrupt configuration vectors and a flat priority table.

A processor may retire interrupts in any order. Retiring the innermost interrupt pops the nesting and restores the previous interrupt and its priority in a single clock. Retiring an interrupt buried deeper in the nesting starts a walk down the back links, one link per clock, until the walk reaches the entry that points at the retired interrupt. That entry is then re-pointed past the retired interrupt. While the walk runs, the unit is busy: it stalls further completions and refuses acknowledges.

Top module: `irq_ack_eoi`

## Requirements
- R1: After reset the running ID is 1023 (no interrupt), the running priority is 0x100 (idle, one above every 8-bit priority), busy is low, and no strobe is active.
- R2: An acknowledge returns 1023 and changes nothing in any of three cases: the highest-pending ID is 1023 or at or above NUM_IRQ, or its priority is not strictly below the running priority (both compared as unsigned 9-bit values).
- R3: A successful acknowledge returns the highest-pending ID in the same cycle. From the next cycle, that ID is the running ID and its priority is the running priority, and the previously running ID is recorded as its back link.
- R4: A successful acknowledge pulses clr_pend in the same cycle, with clr_pend_id equal to the acknowledged ID. clr_pend_all is high exactly when that interrupt's bit in one_of_n is set; otherwise only this processor's pending bit is meant to be cleared.
- R5: The completion ID is bits [9:0] of eoi_data, and the upper bits are ignored. A completion whose ID is at or above NUM_IRQ (1023 included) changes nothing and raises no strobe.
- R6: A completion received while the running ID is 1023 changes nothing and raises no strobe.
- R7: An accepted, in-range completion that arrives while some interrupt is running pulses set_pend in the same cycle, with set_pend_id equal to the completed ID. This happens when that interrupt's edge_trig bit is 0 and its irq_enable, line_level and cpu_target bits are all 1.
- R8: Completing the running ID makes its back link the running ID in the next cycle. The running priority becomes that interrupt's priority-table entry, or 0x100 when the back link is 1023. The running ID is 1023 exactly when the running priority is 0x100.
- R9: Completing an ID other than the running one raises busy from the next cycle for k cycles, and the running ID and priority do not change. If the ID is the k-th link below the running interrupt, the walk re-links around it, so later pops skip it. If the ID is not in the nesting at all, the walk takes (depth) cycles and changes nothing.
- R10: eoi_ready is low while busy is high or while ack_req is high, and a completion presented then is not taken. An acknowledge made while busy returns 1023 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_id | input | IDW | Highest-pending interrupt ID from the arbiter |
| hp_prio | input | PW | Priority of hp_id |
| prio_table | input | NUM_IRQ*PW | Priority of each interrupt, entry i at bits [i*PW +: PW] |
| edge_trig | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| line_level | input | NUM_IRQ | Current level of each source line |
| irq_enable | input | NUM_IRQ | Per-interrupt enable |
| cpu_target | input | NUM_IRQ | Interrupt is routed to this processor |
| one_of_n | input | NUM_IRQ | 1-of-N handling model per interrupt |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_id | output | IDW | Acknowledge result, 1023 when nothing is claimed |
| eoi_valid | input | 1 | End-of-interrupt write valid |
| eoi_data | input | 32 | End-of-interrupt write data |
| eoi_ready | output | 1 | Completion can be taken this cycle |
| run_id | output | IDW | Running interrupt ID |
| run_prio | output | PW+1 | Running priority, 0x100 when idle |
| clr_pend | output | 1 | Clear-pending strobe |
| clr_pend_id | output | IDW | Interrupt whose pending bit is cleared |
| clr_pend_all | output | 1 | Clear for every processor, not just this one |
| set_pend | output | 1 | Set-pending strobe (level source still asserted) |
| set_pend_id | output | IDW | Interrupt to mark pending again |
| busy | output | 1 | Nesting walk in progress |

## Verification
The bench models the nesting as an ordered list of active IDs and compares every output against that list on every clock. Acknowledges are tried with a spurious ID, an equal priority and a worse priority, each of which must be refused, and with a strictly better priority, which must nest. These cases separate a strict comparison from a non-strict one. Completions are tried in five forms: of the innermost interrupt, of one two links deep, of an ID that is not active, with junk in the upper data bits, and with nothing running. The difference between a pop and a walk then shows up in the busy length and in the order that later pops restore. Level re-pend is tried with the source both asserted and released, and a completion and an acknowledge are both presented during a walk to show the stall.

// File: rtl/irq_ack_eoi.sv
module irq_ack_eoi #(
  parameter int NUM_IRQ = 32,
  parameter int IDW     = 10,
  parameter int PW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDW-1:0]        hp_id,
  input  logic [PW-1:0]         hp_prio,
  input  logic [NUM_IRQ*PW-1:0] prio_table,
  input  logic [NUM_IRQ-1:0]    edge_trig,
  input  logic [NUM_IRQ-1:0]    line_level,
  input  logic [NUM_IRQ-1:0]    irq_enable,
  input  logic [NUM_IRQ-1:0]    cpu_target,
  input  logic [NUM_IRQ-1:0]    one_of_n,
  input  logic                  ack_req,
  output logic [IDW-1:0]        ack_id,
  input  logic                  eoi_valid,
  input  logic [31:0]           eoi_data,
  output logic                  eoi_ready,
  output logic [IDW-1:0]        run_id,
  output logic [PW:0]           run_prio,
  output logic                  clr_pend,
  output logic [IDW-1:0]        clr_pend_id,
  output logic                  clr_pend_all,
  output logic                  set_pend,
  output logic [IDW-1:0]        set_pend_id,
  output logic                  busy
);
  localparam int         IW    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam [IDW-1:0]   NONE  = '1;
  localparam [PW:0]      IDLE  = {1'b1, {PW{1'b0}}};
  localparam [IDW:0]     LIMIT = (IDW+1)'(NUM_IRQ);

  logic [IDW-1:0] link [NUM_IRQ];
  logic [IDW-1:0] wcur, wtgt;

  wire [IW-1:0]  ack_idx = hp_id[IW-1:0];
  wire           ack_ok  = ack_req && !busy && ({1'b0, hp_id} < LIMIT)
                           && ({1'b0, hp_prio} < run_prio);

  wire [IDW-1:0] eid     = eoi_data[IDW-1:0];
  wire [IW-1:0]  eidx    = eid[IW-1:0];
  wire           eoi_acc = eoi_valid && eoi_ready;
  wire           eoi_act = eoi_acc && ({1'b0, eid} < LIMIT) && (run_id != NONE);

  wire [IDW-1:0] back      = link[run_id[IW-1:0]];
  wire [PW:0]    back_prio = (back == NONE) ? IDLE
                             : {1'b0, prio_table[back[IW-1:0]*PW +: PW]};
  wire [IDW-1:0] wnext     = link[wcur[IW-1:0]];

  assign eoi_ready    = !busy && !ack_req;
  assign ack_id       = ack_ok ? hp_id : NONE;
  assign clr_pend     = ack_ok;
  assign clr_pend_id  = hp_id;
  assign clr_pend_all = ack_ok && one_of_n[ack_idx];
  assign set_pend     = eoi_act && !edge_trig[eidx] && irq_enable[eidx]
                        && line_level[eidx] && cpu_target[eidx];
  assign set_pend_id  = eid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_id   <= NONE;
      run_prio <= IDLE;
      busy     <= 1'b0;
      wcur     <= NONE;
      wtgt     <= NONE;
      for (int i = 0; i < NUM_IRQ; i++) link[i] <= NONE;
    end else if (ack_ok) begin
      link[ack_idx] <= run_id;
      run_id        <= hp_id;
      run_prio      <= {1'b0, hp_prio};
    end else if (eoi_act) begin
      if (eid == run_id) begin
        run_id   <= back;
        run_prio <= back_prio;
      end else begin
        busy <= 1'b1;
        wcur <= run_id;
        wtgt <= eid;
      end
    end else if (busy) begin
      if (wnext == NONE) begin
        busy <= 1'b0;
      end else if (wnext == wtgt) begin
        link[wcur[IW-1:0]] <= link[wtgt[IW-1:0]];
        busy <= 1'b0;
      end else begin
        wcur <= wnext;
      end
    end
  end

  assert_spurious_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && hp_id == NONE) |-> (ack_id == NONE));
  assert_ack_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> (run_id == $past(clr_pend_id)) && (run_prio == {1'b0, $past(hp_prio)}));
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_pend, set_pend}));
  assert_idle_pairing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NONE) == (run_prio == IDLE));
  assert_walk_holds_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(run_id) && $stable(run_prio));
  assert_walk_from_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(eoi_valid));
  assert_busy_blocks_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !clr_pend && (ack_id == NONE));
endmodule

// File: tb/test_irq_ack_eoi.sv
`timescale 1ns/100ps
module test_irq_ack_eoi;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] hp_id = '1;
  logic [7:0] hp_prio = '0;
  logic [N*8-1:0] prio_table;
  logic [N-1:0] edge_trig = '1, line_level = '0, irq_enable = '0, cpu_target = '0, one_of_n = '0;
  logic ack_req = 1'b0, eoi_valid = 1'b0;
  logic [31:0] eoi_data = '0;
  logic [9:0] ack_id, run_id, clr_pend_id, set_pend_id;
  logic [8:0] run_prio;
  logic eoi_ready, clr_pend, clr_pend_all, set_pend, busy;
  logic [7:0] tbl [N];

  always #2.5 clk = ~clk;
  always_comb for (int i = 0; i < N; i++) prio_table[i*8 +: 8] = tbl[i];

  irq_ack_eoi i_irq_ack_eoi (.clk, .rst_n, .hp_id, .hp_prio, .prio_table, .edge_trig,
    .line_level, .irq_enable, .cpu_target, .one_of_n, .ack_req, .ack_id, .eoi_valid,
    .eoi_data, .eoi_ready, .run_id, .run_prio, .clr_pend, .clr_pend_id, .clr_pend_all,
    .set_pend, .set_pend_id, .busy);

  int checks = 0, fails = 0;
  int q[$];
  int mcnt = 0;
  string tag = "R1";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int mprio();
    return (q.size() == 0) ? 256 : int'(tbl[q[q.size()-1]]);
  endfunction

  task automatic tick();
    int eid, k, last;
    bit ack_ok, eready, eact, setp;
    #1;
    ack_ok = ack_req && mcnt == 0 && hp_id < N && int'(hp_prio) < mprio();
    eready = mcnt == 0 && !ack_req;
    eid    = int'(eoi_data[9:0]);
    eact   = eoi_valid && eready && eid < N && q.size() > 0;
    setp   = eact && !edge_trig[eid] && irq_enable[eid] && line_level[eid] && cpu_target[eid];
    chk("run_id", run_id, q.size() == 0 ? 1023 : q[q.size()-1]);
    chk("run_prio", run_prio, mprio());
    chk("busy", busy, mcnt > 0);
    chk("eoi_ready", eoi_ready, eready);
    chk("ack_id", ack_id, ack_ok ? int'(hp_id) : 1023);
    chk("clr_pend", clr_pend, ack_ok);
    if (ack_ok) begin
      chk("clr_pend_id", clr_pend_id, hp_id);
      chk("clr_pend_all", clr_pend_all, one_of_n[hp_id]);
    end else chk("clr_pend_all", clr_pend_all, 0);
    chk("set_pend", set_pend, setp);
    if (setp) chk("set_pend_id", set_pend_id, eid);
    if (mcnt > 0) mcnt--;
    if (ack_ok) q.push_back(int'(hp_id));
    else if (eact) begin
      last = q.size() - 1;
      if (q[last] == eid) void'(q.pop_back());
      else begin
        k = -1;
        for (int j = last - 1; j >= 0; j--) if (q[j] == eid && k < 0) k = j;
        if (k >= 0) begin mcnt = last - k; q.delete(k); end
        else mcnt = last + 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic ack(int id);
    ack_req = 1'b1; hp_id = 10'(id); hp_prio = (id < N) ? tbl[id] : 8'h00;
    tick();
    ack_req = 1'b0; hp_id = '1;
  endtask

  task automatic eoi(logic [31:0] d);
    eoi_valid = 1'b1; eoi_data = d;
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20 && mcnt > 0; n++) tick();
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) tbl[i] = 8'hC0;
    tbl[10] = 8'h80; tbl[20] = 8'h90; tbl[21] = 8'h80;
    tbl[3] = 8'h40; tbl[7] = 8'h20; tbl[12] = 8'h10; tbl[30] = 8'h50;
    one_of_n[10] = 1'b1;
    edge_trig[30] = 1'b0; irq_enable[30] = 1'b1; line_level[30] = 1'b1; cpu_target[30] = 1'b1;
    edge_trig[7] = 1'b0; irq_enable[7] = 1'b1; line_level[7] = 1'b1; cpu_target[7] = 1'b1;
    edge_trig[12] = 1'b0; irq_enable[12] = 1'b1; line_level[12] = 1'b0; cpu_target[12] = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; tick(); tick();
    tag = "R2"; ack(1023);
    tag = "R6"; eoi(32'd5);
    tag = "R3"; ack(10);
    tag = "R4"; tick();
    tag = "R2"; ack(20); ack(21); ack(40);
    tag = "R3"; ack(3); ack(7);
    tag = "R4"; ack(12); tick();
    tag = "R5"; eoi(32'd40); eoi(32'h0000_03FF);
    tag = "R9"; eoi(32'hABCD_0C03);
    tag = "R10"; ack(0); eoi_valid = 1'b1; eoi_data = 32'd12; tick(); eoi_valid = 1'b0;
    tag = "R9"; wait_idle();
    tag = "R7"; eoi(32'd30);
    tag = "R9"; wait_idle();
    tag = "R8"; eoi(32'd12); tick();
    tag = "R7"; eoi(32'd7); tick();
    tag = "R8"; eoi(32'd10); tick();
    tag = "R6"; eoi(32'd10); tick();
    tag = "R9"; ack(10); ack(3); ack(7); eoi(32'd10); wait_idle();
    tag = "R8"; eoi(32'd7); eoi(32'd3); tick(); tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule